// File: doc/BRIEF.md
# Watchdog Timer with Paired-Clear Option

This block is the watchdog for a small microcontroller core. It counts ticks from one of two sources. The first is the instruction clock, which is the system clock divided by four. The second is a free-running watchdog oscillator, which arrives as a tick strobe already synchronised to the system clock. A static configuration input chooses the source. The ticks drive an 8-bit prescaler and then a 7-bit counter. A software-written select field picks which stage ends the count, so the timeout period is 256·2^n source ticks.

The core hands the watchdog its decoded instruction strobes: a single clear, the first and second halves of a paired clear, and halt. It also supplies a flag that is high while the core is halted. A configuration input picks the clear style. In single mode, one clear instruction restarts the count. In paired mode, both halves must execute, in either order, before the count restarts. When the count expires, the block raises a one-cycle timeout pulse. A companion flag tells the reset logic whether to apply a full chip reset (core running) or a warm reset of the program counter and stack pointer only (core halted). A sticky status flag records a full-reset timeout.

Top module: `wdog_dual_clear`

## Requirements
- R1: After a synchronous reset (`rst` high), `timeout` is 0, `full_reset` is 1, `to_flag` is 0, the select field is 7, and the prescaler, counter and paired-clear latches are zero.
- R2: Writing with `sel_wr` loads `sel_wdata[2:0]` into the select field. `sel_rdata` returns the field in bits 2:0 and zeros in bits 7:3.
- R3: With select code n, `timeout` pulses one cycle after the 256·2^n-th source tick counted since the last clear or timeout. With the instruction clock as source, a tick occurs on every fourth cycle in which the core is not halted.
- R4: `timeout` lasts exactly one cycle, and the prescaler and counter restart from zero after it.
- R5: With `paired_mode` = 0, `clr_single` clears the prescaler and counter, and `clr_first`/`clr_second` have no effect.
- R6: With `paired_mode` = 1, the count clears only once both `clr_first` and `clr_second` have been seen since the last clear, in either order or in the same cycle. A repeat of the same half does not count as the other half, and `clr_single` has no effect.
- R7: `halt_instr` clears the prescaler, the counter and both paired-clear latches. A clear in the same cycle as an expiring tick suppresses the timeout.
- R8: With the instruction clock as source (`src_osc` = 0), counting stops while `halted` is 1. With the oscillator as source (`src_osc` = 1), counting goes on while halted.
- R9: On a timeout, `full_reset` becomes 1 if `halted` was 0 at expiry and 0 otherwise. `to_flag` is set only by a timeout with `halted` at 0.
- R10: `to_flag` is cleared by `rst` and by `halt_instr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high external reset |
| src_osc | input | 1 | Static source select: 0 instruction clock, 1 watchdog oscillator |
| paired_mode | input | 1 | Static clear style: 0 single, 1 paired |
| osc_tick | input | 1 | Synchronised watchdog-oscillator tick strobe |
| halted | input | 1 | Core is in halt mode |
| clr_single | input | 1 | Single clear instruction strobe |
| clr_first | input | 1 | First-half clear instruction strobe |
| clr_second | input | 1 | Second-half clear instruction strobe |
| halt_instr | input | 1 | Halt instruction strobe |
| sel_wr | input | 1 | Select register write strobe |
| sel_wdata | input | 8 | Select register write data |
| sel_rdata | output | 8 | Select register read value |
| timeout | output | 1 | One-cycle expiry pulse |
| full_reset | output | 1 | 1: full chip reset requested, 0: warm reset |
| to_flag | output | 1 | Sticky full-reset timeout status |

## Verification
The bench targets the paired-clear corner cases: a repeated first half, a lone second half after a clear, both halves in reverse order, and both halves in one cycle. A design that treats a repeat as the other half would clear too early and miss the timeout. A design that fails to reset its latches would accept a single later half as a full clear. Halted operation is tested with both sources. An instruction-clock design that keeps counting while halted would fire during the halt. A design that samples the wrong halt state would give the wrong full-versus-warm flag. Long periods (code 7), short periods (codes 0 and 1) and ignored strobes in each mode are covered by a per-cycle reference model, so an off-by-one tap or a strobe that is not ignored shows up at once.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int PRE_W  = 8;
    localparam int CNT_W  = 7;
    localparam int SEL_W  = 3;
    localparam int REG_W  = 8;
    localparam int DIV_W  = 2;

    typedef enum logic {
        SRC_INSTR = 1'b0,
        SRC_OSC   = 1'b1
    } wdt_src_e;

    typedef struct packed {
        logic fire;
        logic warm;
    } wdt_evt_t;

    function automatic logic [REG_W-1:0] pack_sel(input logic [SEL_W-1:0] s);
        logic [REG_W-1:0] r;
        r = '0;
        r[SEL_W-1:0] = s;
        return r;
    endfunction
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
    import wdt_pkg::*;
#(
    parameter int DIV_BITS = DIV_W
) (
    input  logic clk,
    input  logic rst,
    input  logic src_osc,
    input  logic osc_tick,
    input  logic halted,
    output logic tick
);
    localparam logic [DIV_BITS-1:0] DIV_LAST = '1;

    logic [DIV_BITS-1:0] div_q;
    wdt_src_e            src;

    assign src = wdt_src_e'(src_osc);

    always_ff @(posedge clk) begin
        if (rst)          div_q <= '0;
        else if (!halted) div_q <= div_q + 1'b1;
    end

    always_comb begin
        if (src == SRC_OSC) tick = osc_tick;
        else                tick = !halted && (div_q == DIV_LAST);
    end

    assert_halt_stops_instr_R8: assert property (@(posedge clk) disable iff (rst)
        (!src_osc && halted) |-> !tick);
endmodule

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl (
    input  logic clk,
    input  logic rst,
    input  logic paired_mode,
    input  logic clr_single,
    input  logic clr_first,
    input  logic clr_second,
    input  logic halt_instr,
    output logic chain_clr
);
    logic first_q, second_q;
    logic sw_valid;

    always_comb begin
        if (paired_mode) sw_valid = (clr_first || first_q) && (clr_second || second_q);
        else             sw_valid = clr_single;
        chain_clr = halt_instr || sw_valid;
    end

    always_ff @(posedge clk) begin
        if (rst || chain_clr) begin
            first_q  <= 1'b0;
            second_q <= 1'b0;
        end else if (paired_mode) begin
            first_q  <= first_q  || clr_first;
            second_q <= second_q || clr_second;
        end
    end

    assert_half_needed_R6: assert property (@(posedge clk) disable iff (rst)
        (paired_mode && !halt_instr && !clr_first && !first_q) |-> !chain_clr);

    assert_latches_drop_R7: assert property (@(posedge clk) disable iff (rst)
        chain_clr |=> (!first_q && !second_q));
endmodule

// File: rtl/wdt_chain.sv
module wdt_chain
    import wdt_pkg::*;
#(
    parameter int PRE_BITS = PRE_W,
    parameter int CNT_BITS = CNT_W,
    parameter int SEL_BITS = SEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                tick,
    input  logic [SEL_BITS-1:0] sel,
    output logic                ovf
);
    localparam int NTAPS = CNT_BITS + 1;

    logic [PRE_BITS-1:0] pre_q;
    logic [CNT_BITS-1:0] cnt_q;
    logic [NTAPS-1:0]    stage_hit;
    logic                pre_wrap;

    assign stage_hit[0] = 1'b1;
    generate
        for (genvar k = 1; k < NTAPS; k++) begin : g_tap
            assign stage_hit[k] = &cnt_q[k-1:0];
        end
    endgenerate

    assign pre_wrap = tick && (&pre_q);
    assign ovf      = pre_wrap && stage_hit[sel] && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr || ovf) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            pre_q <= pre_q + 1'b1;
            if (&pre_q) cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (pre_q == '0 && cnt_q == '0));

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pre_q == '0 && cnt_q == '0));
endmodule

// File: rtl/wdog_dual_clear.sv
module wdog_dual_clear
    import wdt_pkg::*;
#(
    parameter int PRE_BITS = PRE_W,
    parameter int CNT_BITS = CNT_W,
    parameter int SEL_BITS = SEL_W,
    parameter int REG_BITS = REG_W,
    parameter logic [SEL_BITS-1:0] SEL_RST = '1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                src_osc,
    input  logic                paired_mode,
    input  logic                osc_tick,
    input  logic                halted,
    input  logic                clr_single,
    input  logic                clr_first,
    input  logic                clr_second,
    input  logic                halt_instr,
    input  logic                sel_wr,
    input  logic [REG_BITS-1:0] sel_wdata,
    output logic [REG_BITS-1:0] sel_rdata,
    output logic                timeout,
    output logic                full_reset,
    output logic                to_flag
);
    logic [SEL_BITS-1:0] sel_q;
    logic                tick, chain_clr, ovf;
    wdt_evt_t            evt_q;

    wdt_tick_gen u_tick (
        .clk(clk), .rst(rst), .src_osc(src_osc), .osc_tick(osc_tick),
        .halted(halted), .tick(tick)
    );

    wdt_clear_ctl u_clr (
        .clk(clk), .rst(rst), .paired_mode(paired_mode), .clr_single(clr_single),
        .clr_first(clr_first), .clr_second(clr_second), .halt_instr(halt_instr),
        .chain_clr(chain_clr)
    );

    wdt_chain #(.PRE_BITS(PRE_BITS), .CNT_BITS(CNT_BITS), .SEL_BITS(SEL_BITS)) u_chain (
        .clk(clk), .rst(rst), .clr(chain_clr), .tick(tick), .sel(sel_q), .ovf(ovf)
    );

    always_ff @(posedge clk) begin
        if (rst)         sel_q <= SEL_RST;
        else if (sel_wr) sel_q <= sel_wdata[SEL_BITS-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q   <= '{fire: 1'b0, warm: 1'b0};
            to_flag <= 1'b0;
        end else begin
            evt_q.fire <= ovf;
            if (ovf) evt_q.warm <= halted;
            if (halt_instr)          to_flag <= 1'b0;
            else if (ovf && !halted) to_flag <= 1'b1;
        end
    end

    assign timeout    = evt_q.fire;
    assign full_reset = !evt_q.warm;
    assign sel_rdata  = pack_sel(sel_q);

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout);

    assert_kind_follows_halt_R9: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (full_reset == !$past(halted)));

    assert_full_sets_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (timeout && full_reset) |-> to_flag);

    assert_halt_drops_flag_R10: assert property (@(posedge clk) disable iff (rst)
        halt_instr |=> !to_flag);
endmodule

// File: tb/tb_wdog_dual_clear.sv
`timescale 1ns/1ps
module tb_wdog_dual_clear;
    logic       clk = 1'b0;
    logic       rst, src_osc, paired_mode, osc_tick, halted;
    logic       clr_single, clr_first, clr_second, halt_instr, sel_wr;
    logic [7:0] sel_wdata, sel_rdata;
    logic       timeout, full_reset, to_flag;

    int n_chk = 0, n_fail = 0, cyc = 0, tcount = 0;
    string cur_req = "R1";

    // reference model state
    int m_div, m_total, m_ws;
    bit m_a, m_b, m_tout, m_full, m_to;

    always #2.5 clk = ~clk;

    wdog_dual_clear dut (
        .clk(clk), .rst(rst), .src_osc(src_osc), .paired_mode(paired_mode),
        .osc_tick(osc_tick), .halted(halted), .clr_single(clr_single),
        .clr_first(clr_first), .clr_second(clr_second), .halt_instr(halt_instr),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .sel_rdata(sel_rdata),
        .timeout(timeout), .full_reset(full_reset), .to_flag(to_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic model_step();
        bit tick, valid, clr, ovf;
        int lim;
        if (rst) begin
            m_div = 0; m_total = 0; m_ws = 7; m_a = 0; m_b = 0;
            m_tout = 0; m_full = 1; m_to = 0;
        end else begin
            tick = src_osc ? osc_tick : (!halted && m_div == 3);
            if (!halted) m_div = (m_div + 1) % 4;
            valid = paired_mode ? ((clr_first || m_a) && (clr_second || m_b)) : clr_single;
            clr = halt_instr || valid;
            lim = 256 << m_ws;
            ovf = tick && !clr && (((m_total + 1) % lim) == 0);
            m_tout = ovf;
            if (clr) begin
                m_total = 0; m_a = 0; m_b = 0;
            end else begin
                if (ovf) m_total = 0;
                else if (tick) m_total = (m_total + 1) % 32768;
                if (paired_mode) begin
                    m_a = m_a || clr_first;
                    m_b = m_b || clr_second;
                end
            end
            if (ovf) begin
                m_full = !halted;
                if (!halted) m_to = 1;
            end
            if (halt_instr) m_to = 0;
            if (sel_wr) m_ws = sel_wdata[2:0];
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cyc++;
        if (timeout) tcount++;
        chk(timeout == m_tout, {cur_req, " timeout"}, timeout, m_tout);
        chk(full_reset == m_full, {cur_req, " full_reset"}, full_reset, m_full);
        chk(to_flag == m_to, {cur_req, " to_flag"}, to_flag, m_to);
        chk(sel_rdata == 8'(m_ws), {cur_req, " sel_rdata"}, sel_rdata, m_ws);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset();
        rst = 1'b1; run(2); rst = 1'b0;
    endtask

    task automatic write_sel(input logic [7:0] v);
        sel_wr = 1'b1; sel_wdata = v; step(); sel_wr = 1'b0;
    endtask

    task automatic pulse(input int which);
        case (which)
            0: clr_single = 1'b1;
            1: clr_first  = 1'b1;
            2: clr_second = 1'b1;
            3: begin clr_first = 1'b1; clr_second = 1'b1; end
            default: halt_instr = 1'b1;
        endcase
        step();
        clr_single = 1'b0; clr_first = 1'b0; clr_second = 1'b0; halt_instr = 1'b0;
    endtask

    initial begin
        int limit = 150000;
        while (cyc < limit) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; src_osc = 1'b0; paired_mode = 1'b0; osc_tick = 1'b0; halted = 1'b0;
        clr_single = 1'b0; clr_first = 1'b0; clr_second = 1'b0; halt_instr = 1'b0;
        sel_wr = 1'b0; sel_wdata = 8'h00;
        @(negedge clk);

        // R1: reset state
        cur_req = "R1";
        do_reset();
        chk(timeout == 1'b0, "R1 timeout", timeout, 0);
        chk(full_reset == 1'b1, "R1 full_reset", full_reset, 1);
        chk(to_flag == 1'b0, "R1 to_flag", to_flag, 0);
        chk(sel_rdata == 8'h07, "R1 sel_rdata", sel_rdata, 7);

        // R2: select field readback, upper bits zero
        cur_req = "R2";
        write_sel(8'hFA);
        chk(sel_rdata == 8'h02, "R2 readback", sel_rdata, 2);
        write_sel(8'h00);

        // R3/R4: code 0, instruction clock: 256 ticks = 1024 cycles
        cur_req = "R3";
        do_reset(); write_sel(8'h00); tcount = 0;
        run(1100);
        chk(tcount == 1, "R3 code0 count", tcount, 1);
        chk(to_flag == 1'b1, "R9 to_flag after full timeout", to_flag, 1);

        // R10/R8: halt clears flag; instruction clock frozen while halted
        cur_req = "R10";
        pulse(4);
        chk(to_flag == 1'b0, "R10 to_flag after halt", to_flag, 0);
        cur_req = "R8"; halted = 1'b1; tcount = 0;
        run(3000);
        chk(tcount == 0, "R8 no count while halted", tcount, 0);
        halted = 1'b0;
        run(1000);
        chk(tcount == 0, "R8 resumed from zero", tcount, 0);

        // R3: code 1 gives 2048 cycles
        cur_req = "R3";
        do_reset(); write_sel(8'h01); tcount = 0;
        run(2100);
        chk(tcount == 1, "R3 code1 count", tcount, 1);

        // R5: single mode
        cur_req = "R5";
        do_reset(); write_sel(8'h00); tcount = 0;
        for (int i = 0; i < 6; i++) begin run(499); pulse(0); end
        chk(tcount == 0, "R5 single clears", tcount, 0);
        pulse(3);
        run(1030);
        chk(tcount == 1, "R5 halves ignored", tcount, 1);

        // R6: paired mode
        cur_req = "R6";
        paired_mode = 1'b1;
        do_reset(); write_sel(8'h00); tcount = 0;
        run(600); pulse(1); run(100); pulse(1); run(100); pulse(0); run(300);
        chk(tcount == 1, "R6 repeat first and single ignored", tcount, 1);
        tcount = 0;
        pulse(2); run(900); pulse(2); run(900);
        chk(tcount == 1, "R6 lone second after clear", tcount, 1);
        tcount = 0;
        pulse(1); run(1000);
        chk(tcount == 0, "R6 reverse order clears", tcount, 0);
        pulse(3); run(1000);
        chk(tcount == 0, "R6 same-cycle pair clears", tcount, 0);
        pulse(4); run(1000);
        chk(tcount == 0, "R7 halt clears in paired mode", tcount, 0);
        paired_mode = 1'b0;

        // R8/R9: oscillator source runs while halted, warm reset
        cur_req = "R9";
        src_osc = 1'b1; osc_tick = 1'b1;
        do_reset(); write_sel(8'h00); halted = 1'b1; tcount = 0;
        run(300);
        chk(tcount == 1, "R8 oscillator counts while halted", tcount, 1);
        chk(full_reset == 1'b0, "R9 warm reset when halted", full_reset, 0);
        chk(to_flag == 1'b0, "R9 flag not set when halted", to_flag, 0);
        halted = 1'b0; tcount = 0;
        run(260);
        chk(tcount == 1, "R4 restart after timeout", tcount, 1);
        chk(full_reset == 1'b1, "R9 full reset when running", full_reset, 1);
        chk(to_flag == 1'b1, "R9 flag set when running", to_flag, 1);

        // R3: code 7 with oscillator every cycle: 32768 cycles
        cur_req = "R3";
        do_reset(); write_sel(8'h07); tcount = 0;
        run(32800);
        chk(tcount == 1, "R3 code7 count", tcount, 1);
        src_osc = 1'b0; osc_tick = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule